// File: doc/BRIEF.md
# Paged SRAM Self-Test Engine

This block is a hardware sequencer that proves out the bottom kilobyte of a byte-wide SRAM before anything else on the chip trusts it. It keeps all of its own state in flip-flops and never uses the memory it is testing. The region is handled as four pages of 256 bytes. The engine writes a data background over the whole region, reads it all back and compares, and then moves on. It covers four backgrounds: all zeros, all ones, each byte's own low address byte, and each byte's page number.

An 8-bit status port shows which phase is running, so slow external equipment can follow the progress. A clean run ends with a fixed pass code. On the first miscompare the engine stops touching the memory. The status port then loops through three diagnostic values, each held long enough to be read by eye: the phase code, the failing page shifted into the high nibble, and the failing index. The memory port is synchronous and has one cycle of read latency.

Top module: `sram_selftest_engine`

## Requirements
- R1: While reset is high and on the first cycle after it, busy, done, fail, mem_en and mem_we are 0 and status is 0x00.
- R2: start is acted on only when the engine is idle (never started since reset). busy rises on the clock edge that samples start and stays high until done or fail rises. At most one of busy, done and fail is high at any time. start has no effect while busy or after done or fail.
- R3: Status shows the phase code 0..7. Even codes are write phases and odd codes are check phases, in this order: zeros, ones, self-address, page number. Each phase lasts 1024 cycles, and each check phase is followed by one idle drain cycle. With the start edge counted as cycle 0, status equals 2j in cycles 2049j to 2049j+1023 and 2j+1 in cycles 2049j+1024 to 2049j+2048.
- R4: Within a phase there is one access per cycle. The 8-bit index runs 0..255 as the outer loop and the page runs 0..3 as the inner loop. mem_addr[9:8] holds the page and mem_addr[7:0] holds the index. mem_we is 1 in write phases and 0 in check phases.
- R5: The data written or expected is 0x00 for codes 0/1, 0xFF for codes 2/3, the index for codes 4/5, and the page number for codes 6/7.
- R6: Read data is compared one cycle after the read is issued. A miscompare on a read issued in cycle c makes fail high from cycle c+2.
- R7: On the first miscompare, fail rises and busy falls. After that, mem_en stays 0 and fail stays 1 until reset.
- R8: After a failure, status loops through three values: the phase code, then page*16, then the index. Each value is held for exactly DWELL cycles, and the phase code is shown from the cycle in which fail rises.
- R9: After a clean run, done rises in cycle 8196 and status shows 0x08. After that no memory access is made and status stays 0x08 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a test run (sampled only when idle) |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write enable (valid with mem_en) |
| mem_addr | output | 10 | Access address: page in [9:8], index in [7:0] |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after a read |
| status | output | 8 | Phase code, pass code or rotating diagnostics |
| busy | output | 1 | Test in progress |
| done | output | 1 | Run completed with no miscompare |
| fail | output | 1 | A miscompare was found |

## Verification
The bench targets the following corner cases.
- A miscompare on the last read of a check phase races with the drain cycle and with the advance to the next phase. A design that let the advance win would report the next phase code.
- An alias fault on the page bit survives every background except the page-number one, so only a design with the correct page data catches it.
- An alias on a low index bit is caught only by the self-address background.
- A stuck bit on the very last byte checks that the page and index captured for the diagnostic line up with the delayed compare rather than with the address currently being driven.
- Start pulses in the middle of a run and after done check that a restart cannot corrupt the sequence.

Random stuck-bit and alias faults are checked against a reference model of the test algorithm built into the bench.

// File: rtl/sst_pkg.sv
package sst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_DRAIN,
    ST_PASS,
    ST_FAIL
  } sst_state_e;

  localparam logic [2:0] LAST_PHASE = 3'd7;
  localparam logic [7:0] PASS_CODE  = 8'h08;
endpackage

// File: rtl/sst_addr_seq.sv
// Interleaved address walker: page is the fast field, index the slow one.
module sst_addr_seq #(
  parameter int PAGE_BITS  = 2,
  parameter int INDEX_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clear,
  input  logic                  step,
  output logic [PAGE_BITS-1:0]  page,
  output logic [INDEX_BITS-1:0] index,
  output logic                  last
);
  localparam int CW = PAGE_BITS + INDEX_BITS;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign page  = cnt_q[PAGE_BITS-1:0];
  assign index = cnt_q[CW-1:PAGE_BITS];
  assign last  = &cnt_q;
endmodule

// File: rtl/sst_pattern.sv
// Background generator: phase pair selects the data rule.
module sst_pattern #(
  parameter int PAGE_BITS  = 2,
  parameter int INDEX_BITS = 8,
  parameter int DATA_W     = 8
) (
  input  logic [2:0]            phase,
  input  logic [PAGE_BITS-1:0]  page,
  input  logic [INDEX_BITS-1:0] index,
  output logic [DATA_W-1:0]     data
);
  logic [DATA_W-1:0] index_bg;
  logic [DATA_W-1:0] page_bg;

  generate
    if (DATA_W >= INDEX_BITS) begin : g_idx_wide
      assign index_bg = DATA_W'(index);
    end else begin : g_idx_narrow
      assign index_bg = index[DATA_W-1:0];
    end
  endgenerate

  assign page_bg = DATA_W'(page);

  always_comb begin
    unique case (phase[2:1])
      2'd0:    data = '0;
      2'd1:    data = '1;
      2'd2:    data = index_bg;
      default: data = page_bg;
    endcase
  end
endmodule

// File: rtl/sst_err_display.sv
// Captures the failing location and rotates it onto the status byte.
module sst_err_display #(
  parameter int PAGE_BITS  = 2,
  parameter int INDEX_BITS = 8,
  parameter int DWELL      = 1 << 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [2:0]            phase_in,
  input  logic [PAGE_BITS-1:0]  page_in,
  input  logic [INDEX_BITS-1:0] index_in,
  output logic [7:0]            show
);
  localparam int CW = (DWELL > 2) ? $clog2(DWELL) : 1;
  localparam logic [CW-1:0] DWELL_LAST = CW'(DWELL - 1);

  logic                  active_q;
  logic [1:0]            sel_q;
  logic [CW-1:0]         cnt_q;
  logic [2:0]            phase_q;
  logic [PAGE_BITS-1:0]  page_q;
  logic [INDEX_BITS-1:0] index_q;
  logic [1:0]            sel_nxt;
  logic [7:0]            val_nxt;

  assign sel_nxt = (sel_q == 2'd2) ? 2'd0 : sel_q + 2'd1;

  always_comb begin
    unique case (sel_nxt)
      2'd0:    val_nxt = 8'(phase_q);
      2'd1:    val_nxt = 8'(page_q) << 4;
      default: val_nxt = 8'(index_q);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      sel_q    <= 2'd0;
      cnt_q    <= '0;
      phase_q  <= '0;
      page_q   <= '0;
      index_q  <= '0;
      show     <= 8'h00;
    end else if (load) begin
      active_q <= 1'b1;
      sel_q    <= 2'd0;
      cnt_q    <= '0;
      phase_q  <= phase_in;
      page_q   <= page_in;
      index_q  <= index_in;
      show     <= 8'(phase_in);
    end else if (active_q) begin
      if (cnt_q == DWELL_LAST) begin
        cnt_q <= '0;
        sel_q <= sel_nxt;
        show  <= val_nxt;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sram_selftest_engine.sv
module sram_selftest_engine #(
  parameter int PAGE_BITS  = 2,
  parameter int INDEX_BITS = 8,
  parameter int DATA_W     = 8,
  parameter int DWELL      = 1 << 24
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            start,
  output logic                            mem_en,
  output logic                            mem_we,
  output logic [PAGE_BITS+INDEX_BITS-1:0] mem_addr,
  output logic [DATA_W-1:0]               mem_wdata,
  input  logic [DATA_W-1:0]               mem_rdata,
  output logic [7:0]                      status,
  output logic                            busy,
  output logic                            done,
  output logic                            fail
);
  import sst_pkg::*;

  sst_state_e            state_q;
  logic [2:0]            phase_q;
  logic                  seq_clear;
  logic                  seq_step;
  logic                  seq_last;
  logic [PAGE_BITS-1:0]  cur_page;
  logic [INDEX_BITS-1:0] cur_index;
  logic [DATA_W-1:0]     exp_data;

  logic                  rd_v_q;
  logic [2:0]            rd_phase_q;
  logic [PAGE_BITS-1:0]  rd_page_q;
  logic [INDEX_BITS-1:0] rd_index_q;
  logic [DATA_W-1:0]     rd_exp_q;
  logic                  miscmp;
  logic [7:0]            disp_show;

  assign seq_clear = (state_q == ST_IDLE) && start;
  assign seq_step  = (state_q == ST_RUN);

  sst_addr_seq #(.PAGE_BITS(PAGE_BITS), .INDEX_BITS(INDEX_BITS)) u_seq (
    .clk(clk), .rst(rst), .clear(seq_clear), .step(seq_step),
    .page(cur_page), .index(cur_index), .last(seq_last)
  );

  sst_pattern #(.PAGE_BITS(PAGE_BITS), .INDEX_BITS(INDEX_BITS), .DATA_W(DATA_W)) u_pat (
    .phase(phase_q), .page(cur_page), .index(cur_index), .data(exp_data)
  );

  sst_err_display #(.PAGE_BITS(PAGE_BITS), .INDEX_BITS(INDEX_BITS), .DWELL(DWELL)) u_disp (
    .clk(clk), .rst(rst), .load(miscmp), .phase_in(rd_phase_q),
    .page_in(rd_page_q), .index_in(rd_index_q), .show(disp_show)
  );

  assign mem_en    = (state_q == ST_RUN);
  assign mem_we    = mem_en && !phase_q[0];
  assign mem_addr  = {cur_page, cur_index};
  assign mem_wdata = exp_data;

  assign miscmp = rd_v_q && (mem_rdata != rd_exp_q);

  always_comb begin
    unique case (state_q)
      ST_FAIL: status = disp_show;
      ST_PASS: status = PASS_CODE;
      ST_IDLE: status = 8'h00;
      default: status = 8'(phase_q);
    endcase
  end

  // Read pipeline: carries the location and expected byte to the compare.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_phase_q <= '0;
      rd_page_q  <= '0;
      rd_index_q <= '0;
      rd_exp_q   <= '0;
    end else begin
      rd_phase_q <= phase_q;
      rd_page_q  <= cur_page;
      rd_index_q <= cur_index;
      rd_exp_q   <= exp_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      phase_q <= 3'd0;
      rd_v_q  <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      fail    <= 1'b0;
    end else if (miscmp) begin
      state_q <= ST_FAIL;
      rd_v_q  <= 1'b0;
      busy    <= 1'b0;
      fail    <= 1'b1;
    end else begin
      rd_v_q <= (state_q == ST_RUN) && phase_q[0];
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_RUN;
            phase_q <= 3'd0;
            busy    <= 1'b1;
          end
        end
        ST_RUN: begin
          if (seq_last) begin
            if (phase_q[0]) begin
              state_q <= ST_DRAIN;
            end else begin
              phase_q <= phase_q + 3'd1;
            end
          end
        end
        ST_DRAIN: begin
          if (phase_q == LAST_PHASE) begin
            state_q <= ST_PASS;
            busy    <= 1'b0;
            done    <= 1'b1;
          end else begin
            phase_q <= phase_q + 3'd1;
            state_q <= ST_RUN;
          end
        end
        default: begin
        end
      endcase
    end
  end
endmodule

// File: rtl/sst_checker.sv
module sst_checker (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       mem_en,
  input logic       mem_we,
  input logic [7:0] status,
  input logic       busy,
  input logic       done,
  input logic       fail
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!busy && !done && !fail && !mem_en && !mem_we && status == 8'h00)); // R1

  AST_START_GATES_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(start) && !$past(done) && !$past(fail))); // R2

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(busy && done) && !(busy && fail) && !(done && fail)); // R2

  AST_STATUS_STEPS: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (status == $past(status) || status == $past(status) + 8'd1)); // R3

  AST_WRITE_PHASE: assert property (@(posedge clk) disable iff (rst)
    (busy && mem_en) |-> (mem_we == !status[0])); // R4

  AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_en); // R4

  AST_FAIL_STOPS: assert property (@(posedge clk) disable iff (rst)
    fail |=> (fail && !mem_en && !busy)); // R7

  AST_PASS_HOLDS: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && status == 8'h08 && !mem_en)); // R9

  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_en); // R9
endmodule

bind sram_selftest_engine sst_checker u_chk (
  .clk(clk), .rst(rst), .start(start), .mem_en(mem_en), .mem_we(mem_we),
  .status(status), .busy(busy), .done(done), .fail(fail)
);

// File: tb/tb_sram_selftest_engine.sv
module tb_sram_selftest_engine;
  localparam int DWELL   = 8;
  localparam int SEG     = 2049;
  localparam int RUN_LEN = 4 * SEG;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       mem_en, mem_we;
  logic [9:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [7:0] status;
  logic       busy, done, fail;

  int n_checks = 0;
  int n_fail   = 0;

  // fault model: 0 none, 1 stuck bit at one address, 2 address bit tied low
  int fkind = 0, faddr = 0, fbit = 0, fval = 0;

  always #4 clk = ~clk;

  sram_selftest_engine #(.DWELL(DWELL)) dut (
    .clk(clk), .rst(rst), .start(start), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .status(status), .busy(busy), .done(done), .fail(fail)
  );

  logic [7:0] ram [0:1023];

  function automatic logic [9:0] phys(logic [9:0] a);
    return (fkind == 2) ? (a & ~(10'd1 << fbit)) : a;
  endfunction

  function automatic logic [7:0] faulty(logic [9:0] a, logic [7:0] d);
    logic [7:0] r = d;
    if (fkind == 1 && int'(a) == faddr) r[fbit] = fval[0];
    return r;
  endfunction

  always @(posedge clk) begin
    if (mem_en && mem_we) ram[phys(mem_addr)] <= mem_wdata;
    if (mem_en && !mem_we) mem_rdata <= faulty(mem_addr, ram[phys(mem_addr)]);
  end

  function automatic logic [7:0] pat(int ph, int pg, int idx);
    case (ph / 2)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'(idx);
      default: return 8'(pg);
    endcase
  endfunction

  // Software model of the whole test algorithm against the faulty memory.
  task automatic ref_run(output bit ok, output int ph, output int pg, output int idx);
    logic [7:0] m [1024];
    ok = 1'b1; ph = 0; pg = 0; idx = 0;
    for (int i = 0; i < 1024; i++) m[i] = 8'h00;
    for (int w = 0; w < 8 && ok; w += 2) begin
      for (int x = 0; x < 256; x++)
        for (int p = 0; p < 4; p++)
          m[phys(10'(p * 256 + x))] = pat(w, p, x);
      for (int x = 0; x < 256 && ok; x++)
        for (int p = 0; p < 4 && ok; p++)
          if (faulty(10'(p * 256 + x), m[phys(10'(p * 256 + x))]) != pat(w, p, x)) begin
            ok = 1'b0; ph = w + 1; pg = p; idx = x;
          end
    end
  endtask

  task automatic check(bit cond, string req, string what, int act, int exp);
    n_checks++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic exp_trace(int n, output bit en, output bit we, output int addr,
                           output int wd, output int st);
    int j = n / SEG;
    int r = n % SEG;
    int ph, k;
    en = 0; we = 0; addr = 0; wd = 0;
    if (j >= 4) begin st = 8; return; end
    if (r < 1024) begin ph = 2 * j; k = r; end
    else begin ph = 2 * j + 1; k = r - 1024; end
    st = ph;
    if (r < 2048) begin
      en = 1; we = (ph % 2 == 0);
      addr = (k % 4) * 256 + k / 4;
      wd = pat(ph, k % 4, k / 4);
    end
  endtask

  task automatic run_case(string name, int kind, int fa, int fb, int fv,
                          bit exp_ok, int eph, int epg, int eidx, int glitch);
    int n_end, bad_st, bad_acc, bad_flag, a_st, e_st, a_acc, e_acc;
    fkind = kind; faddr = fa; fbit = fb; fval = fv;
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    n_end = exp_ok ? RUN_LEN : SEG * ((eph - 1) / 2) + 1024 + eidx * 4 + epg + 2;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    bad_st = 0; bad_acc = 0; bad_flag = 0; a_st = 0; e_st = 0; a_acc = 0; e_acc = 0;
    for (int n = 0; n < n_end; n++) begin
      bit en, we;
      int ad, wd, st;
      exp_trace(n, en, we, ad, wd, st);
      if (int'(status) != st) begin
        if (bad_st == 0) begin a_st = status; e_st = st; end
        bad_st++;
      end
      if (mem_en != en || mem_we != we || (en && int'(mem_addr) != ad) ||
          (we && int'(mem_wdata) != wd)) begin
        if (bad_acc == 0) begin a_acc = {mem_en, mem_we, mem_addr, mem_wdata}; e_acc = {en, we, 10'(ad), 8'(wd)}; end
        bad_acc++;
      end
      if (!busy || done || fail) bad_flag++;
      start = (n == glitch);
      @(negedge clk);
    end
    start = 1'b0;
    check(bad_st == 0, "R3", {name, " status trace"}, a_st, e_st);
    check(bad_acc == 0, "R4/R5", {name, " access trace (en,we,addr,data)"}, a_acc, e_acc);
    check(bad_flag == 0, "R2", {name, " busy held, start ignored mid-run"}, bad_flag, 0);
    if (exp_ok) begin
      int bad_hold = 0;
      check(done && !busy && !fail && status == 8'h08, "R9", {name, " pass at cycle 8196"},
            {done, busy, fail, status}, {1'b1, 1'b0, 1'b0, 8'h08});
      for (int k = 0; k < 40; k++) begin
        start = (k % 5 == 0);
        @(negedge clk);
        if (mem_en || !done || status != 8'h08 || busy) bad_hold++;
      end
      start = 1'b0;
      check(bad_hold == 0, "R9", {name, " idle after pass, start ignored"}, bad_hold, 0);
    end else begin
      int seq[3];
      int bad_q = 0;
      seq[0] = eph; seq[1] = epg * 16; seq[2] = eidx;
      check(fail && !busy && !done, "R6/R7", {name, " fail raised at read+2"},
            {fail, busy, done}, 3'b100);
      check(int'(status) == eph, "R8", {name, " phase code shown"}, status, eph);
      for (int k = 1; k <= 6 * DWELL; k++) begin
        start = (k == 3);
        @(negedge clk);
        if (mem_en || !fail || busy) bad_q++;
        if (k % DWELL == 0)
          check(int'(status) == seq[(k / DWELL) % 3], "R8", {name, " rotating diagnostic"},
                status, seq[(k / DWELL) % 3]);
      end
      start = 1'b0;
      check(bad_q == 0, "R7", {name, " no access after fail"}, bad_q, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0C0D));
    repeat (2) @(negedge clk);
    check(!busy && !done && !fail && !mem_en && !mem_we && status == 8'h00, "R1",
          "reset state", {busy, done, fail, mem_en, mem_we, status}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !mem_en && status == 8'h00, "R1", "idle after reset",
          {busy, mem_en, status}, 0);

    run_case("clean", 0, 0, 0, 0, 1'b1, 0, 0, 0, 3000);
    run_case("stuck1@005", 1, 10'h005, 3, 1, 1'b0, 1, 0, 5, 500);
    run_case("stuck0@3FF", 1, 10'h3FF, 7, 0, 1'b0, 3, 3, 255, 2100);
    run_case("alias-a9", 2, 0, 9, 0, 1'b0, 7, 0, 0, 7000);
    run_case("alias-a0", 2, 0, 0, 0, 1'b0, 5, 0, 0, 4200);
    run_case("stuck0@180", 1, 10'h180, 0, 0, 1'b0, 3, 1, 128, 10);

    for (int t = 0; t < 5; t++) begin
      bit ok;
      int ph, pg, idx, k, a, b, v;
      k = $urandom_range(1, 2);
      a = $urandom_range(0, 1023);
      b = (k == 1) ? $urandom_range(0, 7) : $urandom_range(0, 9);
      v = $urandom_range(0, 1);
      fkind = k; faddr = a; fbit = b; fval = v;
      ref_run(ok, ph, pg, idx);
      run_case($sformatf("random%0d", t), k, a, b, v, ok, ph, pg, idx, 100);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule